// File: doc/BRIEF.md
# Switchable Program Bank Mapper

This block sits between the CPU bus and the program ROM of a cartridge. It splits the upper 32 KB of CPU space into four 8 KB windows. Each of the three lower windows ($8000, $A000 and $C000) shows whatever ROM page its own bank register names. The top window ($E000-$FFFF) is tied to the last page of the ROM, so reset vectors and fixed code are always reachable.

Software changes a page by writing to the cartridge range. The low four CPU address bits choose the register, and the data byte carries the new page number. Because the three windows switch independently, program code, a paged data table and a sample buffer can each sit in a window of their own.

The parameter `BANK_W` selects the size of a bank number. With 4 bits the block covers 128 KB of ROM. With 8 bits it covers 2 MB; in that case the extra 4 bits are stored in a second copy of the 4-bit storage that runs in parallel with the first.

Top module: `prg_bank_mapper`

## Requirements
- R1: The low 13 bits of `rom_addr_o` always equal `cpu_addr_i[12:0]`.
- R2: `cpu_addr_i[14:13]` selects the window. The value 0 uses bank register 12, 1 uses register 13, and 2 uses register 14. The bank number appears on `rom_addr_o[BANK_W+12:13]`.
- R3: When `cpu_addr_i[14:13]` is 3, the bank field of `rom_addr_o` is all ones. This holds whatever the bank registers contain and whatever the reset state is.
- R4: A write loads `cpu_data_i[BANK_W-1:0]` into bank register `cpu_addr_i[3:0]` on the rising edge of `clk_i`, for an index of 12, 13 or 14. A write means `cpu_rw_i`=0, `cart_sel_i`=1 and `cpu_addr_i[15]`=1. The new value appears on `rom_addr_o` in the cycle after that edge.
- R5: The bank registers do not change in any of these cases: a write with an index other than 12-14, a write with `cart_sel_i`=0, a write with `cpu_addr_i[15]`=0, or any read (`cpu_rw_i`=1).
- R6: While `rst_ni` is low, all three bank registers are held at zero. The reset is asynchronous and does not wait for a clock edge.
- R7: `rom_ce_o` is 1 exactly when `cpu_rw_i`=1, `cart_sel_i`=1 and `cpu_addr_i[15]`=1.
- R8: With `BANK_W`=4, `cpu_data_i[7:4]` is ignored and the fixed page is 4'hF. With `BANK_W`=8, the whole data byte is stored and the fixed page is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU bus clock; register writes take effect on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_rw_i | input | 1 | 1 = read, 0 = write |
| cart_sel_i | input | 1 | Cartridge select strobe, active high |
| rom_addr_o | output | BANK_W+13 | Program ROM address |
| rom_ce_o | output | 1 | Program ROM chip enable, active high |

## Verification
The assertions check the following on every cycle:
- the offset passes through unchanged (R1);
- the top window always shows the fixed page (R3);
- the chip enable follows the read strobe (R7);
- the write decode selects at most one register;
- a decoded write loads the data byte, and every other cycle leaves the registers stable.

Only the bench scenarios show the rest:
- the mapping from a window to its register (R2);
- asynchronous clearing by reset (R6);
- the difference between the two widths (R8);
- that writes aliased across the whole cartridge range reach the same register.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int WIN_AW   = 13;  // offset bits inside one 8 KB window
  localparam int NUM_SW   = 3;   // switchable windows
  localparam int IDX_W    = 4;   // register index field width
  localparam int IDX_BASE = 12;  // register index of the first switchable window
  localparam int PLANE_W  = 4;   // width of one storage plane

  typedef enum logic [1:0] {
    WIN_LO  = 2'd0,
    WIN_MID = 2'd1,
    WIN_HI  = 2'd2,
    WIN_FIX = 2'd3
  } prg_win_e;
endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
  import prg_map_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic              cpu_rw_i,
  input  logic              cart_sel_i,
  output logic [NUM_SW-1:0] we_o
);
  logic bus_wr;
  assign bus_wr = cart_sel_i & ~cpu_rw_i & cpu_addr_i[15];

  for (genvar w = 0; w < NUM_SW; w++) begin : g_we
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX_BASE + w);
    assign we_o[w] = bus_wr & (cpu_addr_i[IDX_W-1:0] == MY_IDX);
  end

  AST_WE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o)); // R4
  AST_NO_WE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rw_i || !cart_sel_i || !cpu_addr_i[15]) |-> (we_o == '0)); // R5
endmodule

// File: rtl/prg_bank_file.sv
module prg_bank_file
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SW-1:0]              we_i,
  input  logic [7:0]                     data_i,
  output logic [NUM_SW-1:0][BANK_W-1:0]  bank_o
);
  localparam int NUM_PLANES = BANK_W / PLANE_W;

  // one 4-bit register file per plane; planes are written in parallel
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic [NUM_SW-1:0][PLANE_W-1:0] mem_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q <= '0;
      end else begin
        for (int w = 0; w < NUM_SW; w++) begin
          if (we_i[w]) mem_q[w] <= data_i[p*PLANE_W +: PLANE_W];
        end
      end
    end

    for (genvar w = 0; w < NUM_SW; w++) begin : g_rd
      assign bank_o[w][p*PLANE_W +: PLANE_W] = mem_q[w];
    end
  end

  for (genvar w = 0; w < NUM_SW; w++) begin : g_chk
    AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[w] |=> (bank_o[w] == $past(data_i[BANK_W-1:0]))); // R4
    AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i[w] |=> $stable(bank_o[w])); // R5
  end
endmodule

// File: rtl/prg_addr_mux.sv
module prg_addr_mux
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic [15:0]                    cpu_addr_i,
  input  logic [NUM_SW-1:0][BANK_W-1:0]  bank_i,
  output logic [BANK_W+WIN_AW-1:0]       rom_addr_o
);
  prg_win_e          win;
  logic [BANK_W-1:0] sel_bank;

  assign win = prg_win_e'(cpu_addr_i[WIN_AW+1:WIN_AW]);

  always_comb begin
    unique case (win)
      WIN_LO:  sel_bank = bank_i[0];
      WIN_MID: sel_bank = bank_i[1];
      WIN_HI:  sel_bank = bank_i[2];
      default: sel_bank = '1;  // last ROM page
    endcase
  end

  assign rom_addr_o = {sel_bank, cpu_addr_i[WIN_AW-1:0]};
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 8,
  localparam int ROM_AW = BANK_W + WIN_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_rw_i,
  input  logic              cart_sel_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_ce_o
);
  logic [NUM_SW-1:0]             we;
  logic [NUM_SW-1:0][BANK_W-1:0] bank;

  prg_wr_decode i_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_addr_i (cpu_addr_i),
    .cpu_rw_i   (cpu_rw_i),
    .cart_sel_i (cart_sel_i),
    .we_o       (we)
  );

  prg_bank_file #(.BANK_W(BANK_W)) i_file (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .data_i (cpu_data_i),
    .bank_o (bank)
  );

  prg_addr_mux #(.BANK_W(BANK_W)) i_mux (
    .cpu_addr_i (cpu_addr_i),
    .bank_i     (bank),
    .rom_addr_o (rom_addr_o)
  );

  assign rom_ce_o = cart_sel_i & cpu_rw_i & cpu_addr_i[15];

  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o[WIN_AW-1:0] == cpu_addr_i[WIN_AW-1:0]); // R1
  AST_FIXED_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[14:13] == 2'b11) |-> (rom_addr_o[ROM_AW-1:WIN_AW] == '1)); // R3
  AST_CE_WR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rw_i |-> !rom_ce_o); // R7
  AST_CE_DESEL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cart_sel_i || !cpu_addr_i[15]) |-> !rom_ce_o); // R7
endmodule

// File: tb/test_prg_bank_mapper.sv
module test_prg_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        rw = 1'b1;
  logic        sel = 1'b0;
  logic [20:0] rom_a8;
  logic [16:0] rom_a4;
  logic        ce8, ce4;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp8 [3];
  logic [3:0] exp4 [3];

  always #5 clk = ~clk;

  prg_bank_mapper #(.BANK_W(8)) i_prg_bank_mapper (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_data_i(data),
    .cpu_rw_i(rw), .cart_sel_i(sel), .rom_addr_o(rom_a8), .rom_ce_o(ce8));

  prg_bank_mapper #(.BANK_W(4)) i_prg_bank_mapper_nib (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_data_i(data),
    .cpu_rw_i(rw), .cart_sel_i(sel), .rom_addr_o(rom_a4), .rom_ce_o(ce4));

  function automatic logic [20:0] exp_a8(logic [15:0] a);
    logic [7:0] b = (a[14:13] == 2'd3) ? 8'hFF : exp8[a[14:13]];
    return {b, a[12:0]};
  endfunction

  function automatic logic [16:0] exp_a4(logic [15:0] a);
    logic [3:0] b = (a[14:13] == 2'd3) ? 4'hF : exp4[a[14:13]];
    return {b, a[12:0]};
  endfunction

  function automatic logic exp_ce(logic [15:0] a, logic r, logic s);
    return r & s & a[15];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // compare all outputs against the model for the inputs now applied
  task automatic check_outputs(string req);
    chk(req, 32'(rom_a8), 32'(exp_a8(addr)));
    chk(req, 32'(rom_a4), 32'(exp_a4(addr)));
    chk({req, "/R7"}, 32'(ce8), 32'(exp_ce(addr, rw, sel)));
    chk({req, "/R7"}, 32'(ce4), 32'(exp_ce(addr, rw, sel)));
  endtask

  // one bus cycle: drive at falling edge, check before rising edge, update model after it
  task automatic bus(logic [15:0] a, logic [7:0] d, logic r, logic s, string req);
    @(negedge clk);
    addr = a; data = d; rw = r; sel = s;
    #1;
    check_outputs(req);
    @(posedge clk);
    if (!r && s && a[15] && a[3:0] >= 4'd12 && a[3:0] <= 4'd14) begin
      exp8[a[3:0]-4'd12] = d;
      exp4[a[3:0]-4'd12] = d[3:0];
    end
  endtask

  task automatic read_all(string req);
    for (int w = 0; w < 4; w++) bus(16'h8000 | 16'(w << 13) | 16'h0123, 8'h00, 1'b1, 1'b1, req);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin exp8[i] = '0; exp4[i] = '0; end
    void'($urandom(32'h1234_5678));
    #1;
    // R6: reset state, seen while reset is still low
    for (int w = 0; w < 4; w++) begin
      addr = 16'h8000 | 16'(w << 13) | 16'h1ABC; rw = 1'b1; sel = 1'b1;
      #1;
      check_outputs("R6_reset_state");
    end
    #22 rst_n = 1'b1;

    // R2, R4: distinct value per window
    bus(16'h800C, 8'h11, 1'b0, 1'b1, "R4_wr12");
    bus(16'h800D, 8'h22, 1'b0, 1'b1, "R4_wr13");
    bus(16'h800E, 8'h33, 1'b0, 1'b1, "R4_wr14");
    read_all("R2_window_map");
    // R8: high nibble dropped by the narrow build
    bus(16'hF00C, 8'hA5, 1'b0, 1'b1, "R8_wide_vs_narrow");
    read_all("R8_readback");
    // R3: fixed window regardless of registers
    bus(16'hE00E, 8'h7E, 1'b0, 1'b1, "R4_wr_via_top");
    bus(16'hFFFF, 8'h00, 1'b1, 1'b1, "R3_fixed_top");
    bus(16'hE000, 8'h00, 1'b1, 1'b1, "R3_fixed_top_lo");
    // R5: ignored writes
    bus(16'h800B, 8'hEE, 1'b0, 1'b1, "R5_idx11");
    bus(16'h800F, 8'hEE, 1'b0, 1'b1, "R5_idx15");
    bus(16'h800C, 8'hEE, 1'b0, 1'b0, "R5_desel");
    bus(16'h000D, 8'hEE, 1'b0, 1'b1, "R5_a15_low");
    bus(16'h800E, 8'hEE, 1'b1, 1'b1, "R5_read");
    read_all("R5_unchanged");
    // R1: offset extremes
    bus(16'h9FFF, 8'h00, 1'b1, 1'b1, "R1_offset_max");
    bus(16'hA000, 8'h00, 1'b1, 1'b1, "R1_offset_min");

    // random traffic
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] ra = 16'($urandom);
      if ($urandom_range(0, 1) == 1) ra[3:0] = 4'(12 + $urandom_range(0, 2));
      bus(ra, 8'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), "R1_R2_R4_R5_R7_rand");
    end

    // R6: asynchronous clear mid-cycle
    @(negedge clk);
    #2 rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin exp8[i] = '0; exp4[i] = '0; end
    #1;
    for (int w = 0; w < 4; w++) begin
      addr = 16'h8000 | 16'(w << 13); rw = 1'b1; sel = 1'b1;
      #0.5;
      check_outputs("R6_async_clear");
    end
    @(negedge clk);
    rst_n = 1'b1;
    read_all("R6_after_release");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule